// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block holds the programmable state of a platform-level interrupt controller that serves several interrupt contexts, each context being one target that takes interrupts. Software reaches it over a plain 32-bit word bus with separate read and write strobes. Four address regions are decoded. The first holds a priority word per source. The second holds a read-only image of the pending bits. The third holds an enable bitmap per context. The fourth holds a threshold and a claim/complete register per context.

Each interrupt input is a level that is turned into a pending bit on its rising edge. For each context a highest-priority arbiter drives a request line. A read of that context's claim/complete register hands out the winning source ID and moves the source from pending to claimed. Writing the ID back releases it. Writes that land nowhere, or that the region's own screening rejects, leave all state untouched and pulse an error flag.

Top module: `irq_regbank`

## Requirements
- R1: After reset every priority, enable word, threshold, pending bit and claim mark is zero, `irq_req` and `wr_err` are low and `rdata` is zero.
- R2: Source k (1 to NUM_SRC) owns the priority word at PRIO_BASE + 4*(k-1). A write keeps only the low PRIO_W bits, which read back zero-extended.
- R3: The pending word at PEND_BASE + 4*w reads bit b as the pending state of source 32*w + b. Bit 0 of word 0 is always zero. A write there changes nothing and pulses `wr_err`.
- R4: Context c owns EN_WORDS enable words at EN_BASE + c*EN_STRIDE + 4*w, where bit b enables source 32*w + b. A write replaces the whole word. A word index of EN_WORDS or more within the stride is ignored and pulses `wr_err`.
- R5: The threshold of context c sits at CTX_BASE + c*CTX_STRIDE. A value up to 2**PRIO_W-1 is stored. A larger value is dropped and pulses `wr_err`.
- R6: `irq_req[c]` is high exactly when some source is pending, enabled for c and has a priority strictly above the threshold of c.
- R7: A read of CTX_BASE + c*CTX_STRIDE + 4 returns, one cycle later on `rdata`, the qualifying source of highest priority for c, with the lowest ID winning ties, or 0 when none qualifies. The same edge clears that source's pending bit and marks it claimed.
- R8: A write of an ID from 1 to NUM_SRC to a claim/complete register releases that source's claim. Any other ID, and any write to another offset of a context block, changes nothing and pulses `wr_err`.
- R9: A source becomes pending on a rising edge of its input, but only while it is neither pending nor claimed. An edge in the same cycle as the write that completes the source is lost.
- R10: A write to an unmapped or non-word-aligned address changes nothing and pulses `wr_err` for exactly one cycle after the write. Accepted writes leave `wr_err` low, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq | input | NUM_SRC | Interrupt levels; bit k-1 is source k |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| irq_req | output | NUM_CTX | Interrupt request per context |

## Verification
Two collisions between the bus and the interrupt inputs are forced on purpose. In the first, a source input rises in the same cycle as the write that completes that source. The edge must be lost, so the bench checks that the pending image stays clear and that a later fresh edge is accepted. In the second, a claim read coincides with the rising edge of a different, higher-priority source. The read must return the winner chosen before that edge, and the new source must show up as pending and win the next claim.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

   // Decoded target of a bus access
   typedef enum logic [2:0] {
      RG_NONE,   // no region or misaligned
      RG_PRIO,   // source priority word
      RG_PEND,   // pending image word
      RG_EN,     // enable word inside the bitmap
      RG_THR,    // context threshold
      RG_CLM,    // context claim/complete
      RG_BAD     // inside a region but no register there
   } region_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_regbank_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NUM_SRC    = 31,
   parameter int NUM_CTX    = 2,
   parameter int EN_WORDS   = 1,
   parameter int PRIO_BASE  = 'h0000,
   parameter int PEND_BASE  = 'h1000,
   parameter int EN_BASE    = 'h2000,
   parameter int EN_STRIDE  = 'h80,
   parameter int CTX_BASE   = 'h4000,
   parameter int CTX_STRIDE = 'h1000,
   parameter int SRC_W      = 5,
   parameter int CTX_W      = 1,
   parameter int WORD_W     = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [SRC_W-1:0]  src,
   output logic [CTX_W-1:0]  ctx,
   output logic [WORD_W-1:0] word
);

   localparam int E_SH = $clog2(EN_STRIDE);
   localparam int C_SH = $clog2(CTX_STRIDE);

   localparam logic [ADDR_W-1:0] P_LO   = ADDR_W'(PRIO_BASE);
   localparam logic [ADDR_W-1:0] P_HI   = ADDR_W'(PRIO_BASE + NUM_SRC * 4);
   localparam logic [ADDR_W-1:0] Q_LO   = ADDR_W'(PEND_BASE);
   localparam logic [ADDR_W-1:0] Q_HI   = ADDR_W'(PEND_BASE + EN_WORDS * 4);
   localparam logic [ADDR_W-1:0] E_LO   = ADDR_W'(EN_BASE);
   localparam logic [ADDR_W-1:0] E_HI   = ADDR_W'(EN_BASE + NUM_CTX * EN_STRIDE);
   localparam logic [ADDR_W-1:0] C_LO   = ADDR_W'(CTX_BASE);
   localparam logic [ADDR_W-1:0] C_HI   = ADDR_W'(CTX_BASE + NUM_CTX * CTX_STRIDE);
   localparam logic [ADDR_W-1:0] E_MASK = ADDR_W'(EN_STRIDE - 1);
   localparam logic [ADDR_W-1:0] C_MASK = ADDR_W'(CTX_STRIDE - 1);

   logic [ADDR_W-1:0] off_p, off_q, off_e, off_c, in_e, in_c;

   always_comb begin
      off_p  = addr - P_LO;
      off_q  = addr - Q_LO;
      off_e  = addr - E_LO;
      off_c  = addr - C_LO;
      in_e   = off_e & E_MASK;
      in_c   = off_c & C_MASK;
      region = RG_NONE;
      src    = '0;
      ctx    = '0;
      word   = '0;
      if (addr[1:0] != 2'b00) begin
         region = RG_NONE;
      end else if (addr >= P_LO && addr < P_HI) begin
         region = RG_PRIO;
         src    = SRC_W'((off_p >> 2) + ADDR_W'(1));
      end else if (addr >= Q_LO && addr < Q_HI) begin
         region = RG_PEND;
         word   = WORD_W'(off_q >> 2);
      end else if (addr >= E_LO && addr < E_HI) begin
         ctx = CTX_W'(off_e >> E_SH);
         if ((in_e >> 2) < ADDR_W'(EN_WORDS)) begin
            region = RG_EN;
            word   = WORD_W'(in_e >> 2);
         end else begin
            region = RG_BAD;
         end
      end else if (addr >= C_LO && addr < C_HI) begin
         ctx = CTX_W'(off_c >> C_SH);
         if (in_c == '0)
            region = RG_THR;
         else if (in_c == ADDR_W'(4))
            region = RG_CLM;
         else
            region = RG_BAD;
      end
   end

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic take,
   input  logic done,
   output logic pend,
   output logic claimed
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= 1'b0;
         pend    <= 1'b0;
         claimed <= 1'b0;
      end else begin
         lvl_q <= lvl;
         if (take)
            pend <= 1'b0;
         else if (lvl && !lvl_q && !pend && !claimed)
            pend <= 1'b1;
         if (take)
            claimed <= 1'b1;
         else if (done)
            claimed <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int NUM_SRC = 31,
   parameter int PRIO_W  = 3,
   parameter int SRC_W   = 5
) (
   input  logic [NUM_SRC:1]             cand,
   input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]            thr,
   output logic [SRC_W-1:0]             win_id,
   output logic                         req
);

   logic [PRIO_W-1:0] best_p;

   // Strictly greater: a later source never displaces an equal earlier one,
   // and nothing at or below the threshold can win.
   always_comb begin
      win_id = '0;
      best_p = thr;
      for (int i = 1; i <= NUM_SRC; i++) begin
         if (cand[i] && prio[i] > best_p) begin
            win_id = SRC_W'(i);
            best_p = prio[i];
         end
      end
      req = (win_id != '0);
   end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
   import irq_regbank_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NUM_SRC    = 31,
   parameter int NUM_CTX    = 2,
   parameter int PRIO_W     = 3,
   parameter int PRIO_BASE  = 'h0000,
   parameter int PEND_BASE  = 'h1000,
   parameter int EN_BASE    = 'h2000,
   parameter int EN_STRIDE  = 'h80,
   parameter int CTX_BASE   = 'h4000,
   parameter int CTX_STRIDE = 'h1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic               wr_err,
   output logic [NUM_CTX-1:0] irq_req
);

   localparam int EN_WORDS = (NUM_SRC + 32) / 32;
   localparam int BITS     = EN_WORDS * 32;
   localparam int SRC_W    = $clog2(NUM_SRC + 1);
   localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
   localparam int WORD_W   = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
   localparam int MAX_PRIO = (1 << PRIO_W) - 1;

   // Elaboration-time screening of the parameter set
   if (NUM_SRC < 1 || NUM_CTX < 1)
      begin : g_bad_count  $error("irq_regbank: need at least one source and context"); end
   if (PRIO_W < 1 || PRIO_W > 31)
      begin : g_bad_prio   $error("irq_regbank: PRIO_W out of range"); end
   if ((EN_STRIDE & (EN_STRIDE - 1)) != 0 || EN_STRIDE < EN_WORDS * 4)
      begin : g_bad_en     $error("irq_regbank: EN_STRIDE must be a power of two holding the bitmap"); end
   if ((CTX_STRIDE & (CTX_STRIDE - 1)) != 0 || CTX_STRIDE < 8)
      begin : g_bad_ctx    $error("irq_regbank: CTX_STRIDE must be a power of two of at least 8"); end
   if (CTX_BASE + NUM_CTX * CTX_STRIDE > (1 << ADDR_W))
      begin : g_bad_map    $error("irq_regbank: address map exceeds ADDR_W"); end

   // ---------------- decode ----------------
   region_e           dec_region;
   logic [SRC_W-1:0]  dec_src;
   logic [CTX_W-1:0]  dec_ctx;
   logic [WORD_W-1:0] dec_word;

   irq_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .EN_WORDS(EN_WORDS),
      .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
      .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
      .SRC_W(SRC_W), .CTX_W(CTX_W), .WORD_W(WORD_W)
   ) u_dec (
      .addr(addr), .region(dec_region), .src(dec_src), .ctx(dec_ctx), .word(dec_word)
   );

   // ---------------- storage ----------------
   logic [NUM_SRC:0][PRIO_W-1:0]              prio_q;
   logic [NUM_CTX-1:0][EN_WORDS-1:0][31:0]    en_q;
   logic [NUM_CTX-1:0][PRIO_W-1:0]            thr_q;

   logic [BITS-1:0]            pend_vec;
   logic [EN_WORDS-1:0][31:0]  pend_w;
   logic [NUM_SRC:0]           claimed_vec;
   logic [NUM_SRC:1]           take_vec, done_vec;
   logic [NUM_CTX-1:0][SRC_W-1:0] arb_id;

   logic wr_thr_ok, wr_cmp_ok;

   assign wr_thr_ok = (wdata <= 32'(MAX_PRIO));
   assign wr_cmp_ok = (wdata != 32'd0) && (wdata <= 32'(NUM_SRC));

   // ---------------- gateways ----------------
   assign pend_vec[0]    = 1'b0;
   assign claimed_vec[0] = 1'b0;
   if (BITS - 1 > NUM_SRC) begin : g_pend_pad
      assign pend_vec[BITS-1:NUM_SRC+1] = '0;
   end
   assign pend_w = pend_vec;

   for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
      irq_gateway u_gw (
         .clk(clk), .rst_n(rst_n), .lvl(src_irq[s-1]),
         .take(take_vec[s]), .done(done_vec[s]),
         .pend(pend_vec[s]), .claimed(claimed_vec[s])
      );
   end

   // ---------------- per-context arbitration ----------------
   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      logic [BITS-1:0]  en_flat;
      logic [NUM_SRC:1] cand;
      assign en_flat = en_q[c];
      assign cand    = pend_vec[NUM_SRC:1] & en_flat[NUM_SRC:1] & ~claimed_vec[NUM_SRC:1];
      irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb (
         .cand(cand), .prio(prio_q[NUM_SRC:1]), .thr(thr_q[c]),
         .win_id(arb_id[c]), .req(irq_req[c])
      );
   end

   // ---------------- claim / complete strobes ----------------
   always_comb begin
      take_vec = '0;
      done_vec = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
         if (rd_en && dec_region == RG_CLM && arb_id[dec_ctx] == SRC_W'(s))
            take_vec[s] = 1'b1;
         if (wr_en && dec_region == RG_CLM && wr_cmp_ok && wdata == 32'(s))
            done_vec[s] = 1'b1;
      end
   end

   // ---------------- register writes and error flag ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         en_q   <= '0;
         thr_q  <= '0;
         wr_err <= 1'b0;
      end else begin
         wr_err <= 1'b0;
         if (wr_en) begin
            unique case (dec_region)
               RG_PRIO: prio_q[dec_src] <= wdata[PRIO_W-1:0];
               RG_EN:   en_q[dec_ctx][dec_word] <= wdata;
               RG_THR:  if (wr_thr_ok) thr_q[dec_ctx] <= wdata[PRIO_W-1:0];
                        else           wr_err <= 1'b1;
               RG_CLM:  if (!wr_cmp_ok) wr_err <= 1'b1;
               default: wr_err <= 1'b1;
            endcase
         end
      end
   end

   // ---------------- read data ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         unique case (dec_region)
            RG_PRIO: rdata <= 32'(prio_q[dec_src]);
            RG_PEND: rdata <= pend_w[dec_word];
            RG_EN:   rdata <= en_q[dec_ctx][dec_word];
            RG_THR:  rdata <= 32'(thr_q[dec_ctx]);
            RG_CLM:  rdata <= 32'(arb_id[dec_ctx]);
            default: rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
   parameter int ADDR_W     = 16,
   parameter int NUM_SRC    = 31,
   parameter int NUM_CTX    = 2,
   parameter int PRIO_W     = 3,
   parameter int PEND_BASE  = 'h1000,
   parameter int CTX_BASE   = 'h4000,
   parameter int CTX_STRIDE = 'h1000,
   parameter int BITS       = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [31:0]        wdata,
   input logic               wr_err,
   input logic [NUM_CTX-1:0] irq_req,
   input logic [BITS-1:0]    pend_vec,
   input logic [NUM_SRC:0]   claimed_vec
);

   localparam int PEND_END = PEND_BASE + 4 * (BITS / 32);
   localparam int CTX_END  = CTX_BASE + NUM_CTX * CTX_STRIDE;

   logic in_pend, in_ctx, thr_hit, clm0_hit;
   logic [ADDR_W-1:0] ctx_off;

   assign ctx_off  = (addr - ADDR_W'(CTX_BASE)) & ADDR_W'(CTX_STRIDE - 1);
   assign in_pend  = (32'(addr) >= PEND_BASE) && (32'(addr) < PEND_END);
   assign in_ctx   = (32'(addr) >= CTX_BASE) && (32'(addr) < CTX_END);
   assign thr_hit  = in_ctx && ctx_off == '0;
   assign clm0_hit = (32'(addr) == CTX_BASE + 4);

   // R3
   pend_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && in_pend |=> wr_err);

   // R5
   thr_range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && thr_hit && wdata > 32'((1 << PRIO_W) - 1) |=> wr_err);

   // R7
   pend_claim_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec[NUM_SRC:0] & claimed_vec) == '0);

   // R6
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vec == '0 |-> irq_req == '0);

   // R7
   claim_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && clm0_hit && irq_req[0]
      |=> $countones(claimed_vec) == $past($countones(claimed_vec)) + 1);

   // R10
   misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr[1:0] != 2'b00 |=> wr_err);

   // R10
   no_write_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !wr_err);

endmodule

bind irq_regbank irq_regbank_chk #(
   .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W),
   .PEND_BASE(PEND_BASE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
   .BITS(BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .wr_err(wr_err), .irq_req(irq_req),
   .pend_vec(pend_vec), .claimed_vec(claimed_vec)
);

// File: tb/irq_regbank_test.sv
module irq_regbank_test;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 31;
   localparam int NCTX = 2;

   localparam logic [15:0] A_PRIO = 16'h0000;
   localparam logic [15:0] A_PEND = 16'h1000;
   localparam logic [15:0] A_EN   = 16'h2000;
   localparam logic [15:0] A_CTX  = 16'h4000;
   localparam logic [15:0] EN_STR = 16'h0080;
   localparam logic [15:0] CX_STR = 16'h1000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_irq = '0;
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [15:0]     addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic            wr_err;
   logic [NCTX-1:0] irq_req;

   int vectors = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_regbank uut (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .wr_err(wr_err), .irq_req(irq_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One write cycle; checks the error pulse that follows it
   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic exp_err, input string req);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      check(req, 32'(wr_err), 32'(exp_err));
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string req);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic t_reset();
      check("R1 irq_req", 32'(irq_req), 32'd0);
      check("R1 wr_err", 32'(wr_err), 32'd0);
      check("R1 rdata", rdata, 32'd0);
      rd_chk(A_PRIO + 16'd8, 32'd0, "R1 priority");
      rd_chk(A_PEND, 32'd0, "R1 pending");
      rd_chk(A_EN + EN_STR, 32'd0, "R1 enable");
      rd_chk(A_CTX + CX_STR, 32'd0, "R1 threshold");
   endtask

   task automatic t_priority();
      wr(A_PRIO + 16'd16, 32'hFFFF_FFFD, 1'b0, "R2 write ok");
      rd_chk(A_PRIO + 16'd16, 32'd5, "R2 low bits kept");
      rd_chk(A_PRIO + 16'd12, 32'd0, "R2 neighbour untouched");
   endtask

   task automatic t_enable();
      wr(A_EN + EN_STR, 32'hA5A5_5A5A, 1'b0, "R4 write ok");
      rd_chk(A_EN + EN_STR, 32'hA5A5_5A5A, "R4 readback");
      wr(A_EN + EN_STR + 16'd4, 32'hFFFF_FFFF, 1'b1, "R4 word beyond bitmap err");
      rd_chk(A_EN + EN_STR, 32'hA5A5_5A5A, "R4 unchanged after bad word");
      wr(A_EN + EN_STR, 32'h0000_0004, 1'b0, "R4 rewrite");
   endtask

   task automatic t_threshold();
      wr(A_CTX, 32'd8, 1'b1, "R5 over top err");
      rd_chk(A_CTX, 32'd0, "R5 unchanged");
      wr(A_CTX, 32'd7, 1'b0, "R5 top accepted");
      rd_chk(A_CTX, 32'd7, "R5 readback");
      wr(A_CTX, 32'd0, 1'b0, "R5 restore");
   endtask

   task automatic t_arbitrate();
      wr(A_PRIO + 16'd4,  32'd3, 1'b0, "R2 src2");
      wr(A_PRIO + 16'd24, 32'd5, 1'b0, "R2 src7");
      wr(A_PRIO + 16'd32, 32'd5, 1'b0, "R2 src9");
      wr(A_EN, 32'h0000_0284, 1'b0, "R4 ctx0");
      check("R6 no request before edges", 32'(irq_req), 32'd0);
      @(negedge clk);
      src_irq[1] = 1'b1; src_irq[6] = 1'b1; src_irq[8] = 1'b1;
      @(negedge clk);
      check("R9 edges latched / R6 both request", 32'(irq_req), 32'b11);
      rd_chk(A_PEND, 32'h0000_0284, "R3 pending image");
      wr(A_PEND, 32'd0, 1'b1, "R3 pending write err");
      rd_chk(A_PEND, 32'h0000_0284, "R3 pending unchanged");
      wr(A_CTX, 32'd5, 1'b0, "R5 ctx0 thr5");
      check("R6 equal to threshold masks", 32'(irq_req), 32'b10);
      wr(A_CTX + CX_STR, 32'd3, 1'b0, "R5 ctx1 thr3");
      check("R6 both masked", 32'(irq_req), 32'b00);
      wr(A_CTX, 32'd4, 1'b0, "R5 ctx0 thr4");
      check("R6 above threshold", 32'(irq_req), 32'b01);
      wr(A_CTX, 32'd0, 1'b0, "R5 ctx0 thr0");
      wr(A_CTX + CX_STR, 32'd0, 1'b0, "R5 ctx1 thr0");
   endtask

   task automatic t_claim();
      rd_chk(A_CTX + 16'd4, 32'd7, "R7 tie lowest id");
      rd_chk(A_PEND, 32'h0000_0204, "R7 pending cleared");
      rd_chk(A_CTX + 16'd4, 32'd9, "R7 next winner");
      rd_chk(A_CTX + CX_STR + 16'd4, 32'd2, "R7 ctx1 winner");
      rd_chk(A_CTX + 16'd4, 32'd0, "R7 none left");
      check("R6 idle after claims", 32'(irq_req), 32'b00);
   endtask

   task automatic t_gateway();
      @(negedge clk);
      src_irq[6] = 1'b0; src_irq[8] = 1'b0;
      @(negedge clk);
      src_irq[6] = 1'b1;
      @(negedge clk);
      rd_chk(A_PEND, 32'd0, "R9 edge while claimed ignored");
      wr(A_CTX + 16'd4, 32'd7, 1'b0, "R8 complete ok");
      rd_chk(A_PEND, 32'd0, "R9 level alone no pend");
      @(negedge clk);
      src_irq[6] = 1'b0;
      @(negedge clk);
      src_irq[6] = 1'b1;
      @(negedge clk);
      rd_chk(A_PEND, 32'h0000_0080, "R9 fresh edge pends");
      check("R6 request again", 32'(irq_req), 32'b01);
      rd_chk(A_CTX + CX_STR + 16'd4, 32'd0, "R7 not enabled in ctx1");
   endtask

   task automatic t_collide();
      logic [31:0] d;
      @(negedge clk);
      src_irq[1] = 1'b0;
      @(negedge clk);
      wr_en = 1'b1; addr = A_CTX + 16'd4; wdata = 32'd2; src_irq[1] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check("R8 complete src2", 32'(wr_err), 32'd0);
      rd_chk(A_PEND, 32'h0000_0080, "R9 edge lost at completion");
      wr(A_CTX + 16'd4, 32'd9, 1'b0, "R8 complete src9");
      wr(A_PRIO + 16'd32, 32'd6, 1'b0, "R2 src9 raised");
      @(negedge clk);
      rd_en = 1'b1; addr = A_CTX + 16'd4; src_irq[8] = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R7 claim before new edge", rdata, 32'd7);
      rd_chk(A_PEND, 32'h0000_0200, "R9 edge taken beside claim");
      rd(A_CTX + 16'd4, d);
      check("R7 new source wins next", d, 32'd9);
   endtask

   task automatic t_errors();
      wr(A_CTX + 16'd4, 32'd0, 1'b1, "R8 id zero err");
      wr(A_CTX + 16'd4, 32'd32, 1'b1, "R8 id too big err");
      wr(A_CTX + 16'd8, 32'd1, 1'b1, "R8 other offset err");
      wr(A_PRIO + 16'd2, 32'd7, 1'b1, "R10 misaligned err");
      rd_chk(A_PRIO, 32'd0, "R10 misaligned no change");
      wr(16'h3000, 32'hDEAD_BEEF, 1'b1, "R10 unmapped err");
      rd_chk(16'h3000, 32'd0, "R10 unmapped read zero");
      @(negedge clk);
      check("R10 pulse one cycle", 32'(wr_err), 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_priority();
      t_enable();
      t_threshold();
      t_arbitrate();
      t_claim();
      t_gateway();
      t_collide();
      t_errors();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule